// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block paces the clock line of an I2C master. A packed divider word supplies two fields. A prescale field sets how many peripheral clock cycles make one internal tick. A gap field lengthens each SCL period in steps of 8 ticks. The internal tick is a one-cycle enable pulse, not a derived clock. Each period consists of two base halves of 10 + 4×gap ticks each. The first half drives SCL low. Then the line is released, and the high half starts counting only when the synchronised line is seen high on a tick. Slow rise times and slaves that hold SCL low therefore extend the period by whole ticks, and the base count is never shortened.

The bit engine of the controller gets two one-cycle strobes. A drive strobe at mid-low tells it when to change SDA. A sample strobe at mid-high tells it when to read SDA. When the enable is low, the generator releases SCL, goes quiet and clears its counters. A new enable always begins with a full low half.

Top module: `i2c_scl_timer`

## Requirements
- R1: One internal tick lasts CDF+1 peripheral clock cycles, where CDF is the prescale field. All phase lengths are whole numbers of ticks.
- R2: The divider word carries CDF in its low CDF_W bits and the gap field SCGD in the GAP_W bits directly above it.
- R3: Each low phase drives `scl_low_en` for exactly (10 + 4×SCGD)×(CDF+1) cycles.
- R4: After the line is released, the high count starts only on a tick where the synchronised SCL input reads high. A slow rise or a slave holding SCL low lengthens the released time by whole ticks.
- R5: The high phase lasts (10 + 4×SCGD) ticks from the qualifying tick. The next low phase then begins at once.
- R6: When the line rises at once, one SCL period is 20 + 8×SCGD ticks plus the synchroniser wait.
- R7: `sda_drive_stb` pulses for one cycle, on the tick with index 5 + 2×SCGD (counting from 0) of each low phase, and only while SCL is driven low.
- R8: `sda_sample_stb` pulses for one cycle, on the tick with index 5 + 2×SCGD of each high phase, and only while SCL is released.
- R9: `scl_in` passes through SYNC_STAGES flip-flops before the phase logic uses it. With CDF=0 and a line that rises at once, the released time is SYNC_STAGES+1+10+4×SCGD cycles.
- R10: In the cycle after `enable` is sampled low, SCL is released and both strobes are silent. In the cycle after `enable` rises, a full-length low phase begins.
- R11: During reset, SCL is released and neither strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; low releases SCL and clears counters |
| div_word | input | CDF_W+GAP_W | Packed divider: {SCGD, CDF} |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_low_en | output | 1 | Pull SCL low when 1, release when 0 |
| sda_drive_stb | output | 1 | One-cycle strobe at mid-low for changing SDA |
| sda_sample_stb | output | 1 | One-cycle strobe at mid-high for sampling SDA |

## Verification
The checks assume that `div_word` stays constant while `enable` is high. If it changes mid-phase, the low-length property has no defined expected value. The stimulus therefore changes the divider only when the generator is disabled. The checks also assume that `scl_in` behaves like a wired line, reading low whenever the block itself drives low. The bench models an open-drain line with a configurable rise delay and a stretching slave, so this holds throughout. Each configuration runs across several whole periods, and one run drops `enable` in the middle of a low phase.

// File: rtl/i2c_scl_timer_pkg.sv
package i2c_scl_timer_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_LOW   = 2'd1,
      PH_WAITH = 2'd2,
      PH_HIGH  = 2'd3
   } scl_phase_e;

   localparam int unsigned BASE_HALF = 10;
   localparam int unsigned GAP_STEP  = 4;

endpackage

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
   parameter int unsigned CDF_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CDF_W-1:0] cdf,
   output logic             tick
);

   logic [CDF_W-1:0] pre_cnt;

   assign tick = run && (pre_cnt == cdf);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_cnt <= '0;
      else if (!run || tick)
         pre_cnt <= '0;
      else
         pre_cnt <= pre_cnt + 1'b1;
   end

endmodule

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b1;
            else        chain[0] <= d;
         end
         for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
   import i2c_scl_timer_pkg::*;
#(
   parameter int unsigned HALF_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tick,
   input  logic              scl_seen,
   input  logic [HALF_W-1:0] half,
   input  logic [HALF_W-1:0] mid,
   output logic              run,
   output logic              scl_low_en,
   output logic              drv_stb,
   output logic              smp_stb
);

   scl_phase_e        ph;
   logic [HALF_W-1:0] cnt;
   logic [HALF_W-1:0] last;
   logic              at_end;

   assign last   = half - HALF_W'(1);
   assign at_end = (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else if (!enable) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else begin
         unique case (ph)
            PH_IDLE: begin
               ph  <= PH_LOW;
               cnt <= '0;
            end
            PH_LOW: begin
               if (tick) begin
                  if (at_end) begin
                     ph  <= PH_WAITH;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            PH_WAITH: begin
               if (tick && scl_seen) begin
                  ph  <= PH_HIGH;
                  cnt <= '0;
               end
            end
            PH_HIGH: begin
               if (tick) begin
                  if (at_end) begin
                     ph  <= PH_LOW;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: begin
               ph  <= PH_IDLE;
               cnt <= '0;
            end
         endcase
      end
   end

   assign run        = (ph != PH_IDLE);
   assign scl_low_en = (ph == PH_LOW);
   assign drv_stb    = tick && (ph == PH_LOW)  && (cnt == mid);
   assign smp_stb    = tick && (ph == PH_HIGH) && (cnt == mid);

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
   import i2c_scl_timer_pkg::*;
#(
   parameter int unsigned CDF_W       = 2,
   parameter int unsigned GAP_W       = 6,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned DIV_W      = CDF_W + GAP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [DIV_W-1:0] div_word,
   input  logic             scl_in,
   output logic             scl_low_en,
   output logic             sda_drive_stb,
   output logic             sda_sample_stb
);

   localparam int unsigned HALF_MAX = BASE_HALF + GAP_STEP * ((1 << GAP_W) - 1);
   localparam int unsigned HALF_W   = $clog2(HALF_MAX + 1);

   generate
      if (CDF_W < 1 || CDF_W > 8) begin : g_bad_cdf
         $error("CDF_W must lie in 1..8");
      end
      if (GAP_W < 1 || GAP_W > 8) begin : g_bad_gap
         $error("GAP_W must lie in 1..8");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [CDF_W-1:0]  cdf;
   logic [GAP_W-1:0]  gap;
   logic [HALF_W-1:0] half;
   logic [HALF_W-1:0] mid;
   logic              tick;
   logic              run;
   logic              scl_seen;

   assign cdf  = div_word[CDF_W-1:0];
   assign gap  = div_word[DIV_W-1:CDF_W];
   assign half = HALF_W'(BASE_HALF) + (HALF_W'(gap) << 2);
   assign mid  = half >> 1;

   scl_tick_gen #(.CDF_W(CDF_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .cdf   (cdf),
      .tick  (tick)
   );

   scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (scl_in),
      .q     (scl_seen)
   );

   scl_phase_fsm #(.HALF_W(HALF_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .tick       (tick),
      .scl_seen   (scl_seen),
      .half       (half),
      .mid        (mid),
      .run        (run),
      .scl_low_en (scl_low_en),
      .drv_stb    (sda_drive_stb),
      .smp_stb    (sda_sample_stb)
   );

endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk #(
   parameter int unsigned CDF_W = 2,
   parameter int unsigned GAP_W = 6
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   enable,
   input logic [CDF_W+GAP_W-1:0] div_word,
   input logic                   scl_low_en,
   input logic                   sda_drive_stb,
   input logic                   sda_sample_stb
);

   logic [31:0] low_run;
   int unsigned exp_low;

   assign exp_low = (10 + 4 * int'(div_word[CDF_W+GAP_W-1:CDF_W]))
                  * (int'(div_word[CDF_W-1:0]) + 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          low_run <= '0;
      else if (scl_low_en) low_run <= low_run + 1;
      else                 low_run <= '0;
   end

   // R10
   release_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!scl_low_en && !sda_drive_stb && !sda_sample_stb));

   // R10
   restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enable) |=> scl_low_en);

   // R7
   drive_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_drive_stb |-> scl_low_en);

   // R8
   sample_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_sample_stb |-> !scl_low_en);

   // R3
   low_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scl_low_en) && $past(enable)) |-> (low_run == exp_low));

endmodule

bind i2c_scl_timer i2c_scl_timer_chk #(.CDF_W(CDF_W), .GAP_W(GAP_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .enable         (enable),
   .div_word       (div_word),
   .scl_low_en     (scl_low_en),
   .sda_drive_stb  (sda_drive_stb),
   .sda_sample_stb (sda_sample_stb)
);

// File: tb/i2c_scl_timer_tb_top.sv
module i2c_scl_timer_tb_top;

   localparam int CDF_W = 2;
   localparam int GAP_W = 6;
   localparam int SYNC  = 2;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   enable = 1'b0;
   logic [CDF_W+GAP_W-1:0] div_word = '0;
   logic                   scl_line = 1'b1;
   logic                   scl_low_en, sda_drive_stb, sda_sample_stb;

   int checks = 0, fails = 0, cyc = 0;
   bit stretch = 0;
   int rise_cyc = 0, rel_cnt = 0;

   always #4 clk = ~clk;

   i2c_scl_timer #(.CDF_W(CDF_W), .GAP_W(GAP_W), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .div_word(div_word),
      .scl_in(scl_line), .scl_low_en(scl_low_en),
      .sda_drive_stb(sda_drive_stb), .sda_sample_stb(sda_sample_stb));

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_gt(string tag, int act, int bound);
      checks++;
      if (act <= bound) begin
         fails++;
         $display("FAIL %s actual=%0d expected>%0d", tag, act, bound);
      end
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // open-drain line with rise delay and stretching slave
   always @(negedge clk) begin
      if (scl_low_en || stretch) rel_cnt = 0;
      else rel_cnt++;
      scl_line = !scl_low_en && !stretch && (rel_cnt > rise_cyc);
   end

   // pre-edge snapshot of everything the model consumes
   bit s_rst = 0, s_en = 0, s_scl = 1;
   int s_div = 0;
   always @(negedge clk) begin
      #3;
      s_rst = rst_n; s_en = enable; s_div = int'(div_word); s_scl = scl_line;
   end

   // behavioural reference model: phase and cycles spent in it
   int mph = 0, mcyc = 0;
   bit mq[$];
   initial for (int i = 0; i < SYNC; i++) mq.push_back(1'b1);

   always @(posedge clk) begin : model
      bit seen;
      int per, half;
      if (!s_rst) begin
         mph = 0; mcyc = 0; mq = {};
         for (int i = 0; i < SYNC; i++) mq.push_back(1'b1);
      end else begin
         per  = (s_div % (1 << CDF_W)) + 1;
         half = 10 + 4 * (s_div >> CDF_W);
         if (SYNC == 0) seen = s_scl;
         else begin
            seen = mq[0];
            void'(mq.pop_front());
            mq.push_back(s_scl);
         end
         if (!s_en) begin
            mph = 0; mcyc = 0;
         end else begin
            case (mph)
               0: begin mph = 1; mcyc = 0; end
               1: if (mcyc == half * per - 1) begin mph = 2; mcyc = 0; end
                  else mcyc++;
               2: if (((mcyc + 1) % per == 0) && seen) begin mph = 3; mcyc = 0; end
                  else mcyc++;
               default: if (mcyc == half * per - 1) begin mph = 1; mcyc = 0; end
                  else mcyc++;
            endcase
         end
      end
   end

   // per-cycle comparison and run-length tracking
   bit prev_low = 0;
   int run = 0, last_low = 0, last_rel = 0, n_rise = 0, n_fall = 0;
   int n_drv = 0, n_smp = 0, drv_pos = 0, smp_pos = 0;

   always @(posedge clk) begin : compare
      int per, half, midp;
      string tag;
      #2;
      if (rst_n) begin
         per  = (int'(div_word) % (1 << CDF_W)) + 1;
         half = 10 + 4 * (int'(div_word) >> CDF_W);
         midp = ((half / 2) + 1) * per - 1;
         case (mph)
            0: tag = "R10 scl_low_en";
            1: tag = "R3 scl_low_en";
            2: tag = "R4 scl_low_en";
            default: tag = "R5 scl_low_en";
         endcase
         chk(tag, int'(scl_low_en), int'(mph == 1));
         chk("R7 sda_drive_stb", int'(sda_drive_stb), int'(mph == 1 && mcyc == midp));
         chk("R8 sda_sample_stb", int'(sda_sample_stb), int'(mph == 3 && mcyc == midp));
      end
      if (scl_low_en != prev_low) begin
         if (prev_low) begin last_low = run; n_fall++; end
         else begin last_rel = run; n_rise++; end
         run = 1;
      end else run++;
      prev_low = scl_low_en;
      if (sda_drive_stb)  begin n_drv++; drv_pos = run; end
      if (sda_sample_stb) begin n_smp++; smp_pos = run; end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected<=150000", cyc);
         report();
         $finish;
      end
   end

   task automatic cfg(int cdf, int gap);
      div_word = (CDF_W + GAP_W)'((gap << CDF_W) | cdf);
   endtask

   task automatic wait_rises(int n);
      int base = n_rise;
      while (n_rise < base + n) @(posedge clk);
   endtask

   task automatic wait_falls(int n);
      int base = n_fall;
      while (n_fall < base + n) @(posedge clk);
   endtask

   task automatic stop_gen();
      @(negedge clk); enable = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      int d0;
      cfg(0, 0);
      repeat (3) @(posedge clk);
      #2;
      chk("R11 scl_low_en in reset", int'(scl_low_en), 0);
      chk("R11 strobes in reset", int'(sda_drive_stb | sda_sample_stb), 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // fast line, CDF=0, SCGD=0
      enable = 1'b1;
      wait_rises(2);
      chk("R3 low cycles", last_low, 10);
      chk("R9 released cycles", last_rel, SYNC + 1 + 10);
      chk("R6 period cycles", last_low + last_rel, 23);
      chk("R7 drive strobe position", drv_pos, 6);
      chk("R8 sample strobe position", smp_pos, SYNC + 1 + 6);
      d0 = n_drv;
      wait_rises(1);
      chk("R7 one drive strobe per period", n_drv - d0, 1);
      stop_gen();

      // CDF=1, SCGD=1
      cfg(1, 1);
      @(negedge clk); enable = 1'b1;
      wait_rises(3);
      chk("R2 low cycles", last_low, 28);
      chk("R5 released cycles", last_rel, 4 + 28);
      stop_gen();

      // CDF=3, SCGD=2, slow rise
      cfg(3, 2); rise_cyc = 5;
      @(negedge clk); enable = 1'b1;
      wait_rises(3);
      chk("R1 low cycles", last_low, 72);
      chk("R4 released cycles slow rise", last_rel, 8 + 72);
      stop_gen();

      // slave stretching
      cfg(0, 0); rise_cyc = 0;
      @(negedge clk); stretch = 1'b1; enable = 1'b1;
      wait_falls(1);
      repeat (40) @(negedge clk);
      stretch = 1'b0;
      wait_rises(1);
      chk_gt("R4 stretched released cycles", last_rel, 50);
      stop_gen();

      // disable mid-low and restart
      cfg(1, 0);
      @(negedge clk); enable = 1'b1;
      repeat (7) @(negedge clk);
      enable = 1'b0;
      @(posedge clk); #2;
      chk("R10 released after disable", int'(scl_low_en), 0);
      repeat (2) @(negedge clk);
      enable = 1'b1;
      wait_falls(1);
      chk("R10 full low after restart", last_low, 20);
      stop_gen();

      report();
      $finish;
   end

endmodule